// File: doc/BRIEF.md
# Registered Three-Port Bus Exchanger

This block connects a processor-side data port (A) to two memory-side ports, one for the even bank (1B) and one for the odd bank (2B). All three ports are 12 bits wide by default. Four registers carry the data, each with its own active-low load enable. Two of them send A towards 1B and 2B, and two bring 1B and 2B back towards A. A path select is captured on the rising clock edge and decides which return register appears on A.

Each bidirectional port is split into an input bus, an output bus and a drive flag, so the surrounding logic or pad ring can build the actual three-state driver. Both output enables are synchronous and active low. One enable governs port A. A second enable governs 1B and 2B together. Each drive flag is a flop that changes on the same edge as the data. An active-low asynchronous reset clears every data register, the captured select and both drive flags.

Top module: `bus_exchanger`

## Requirements
- R1: When `ld_ab1_ni` is 0 at a rising edge, `b1_o` shows the `a_i` sampled at that edge. When it is 1, `b1_o` is unchanged.
- R2: When `ld_ab2_ni` is 0 at a rising edge, `b2_o` shows the `a_i` sampled at that edge. When it is 1, `b2_o` is unchanged, whatever `ld_ab1_ni` does.
- R3: With `sel_b1_i`=1 and `ld_b1a_ni`=0 at an edge, `a_o` shows the sampled `b1_i` after that edge.
- R4: With `sel_b1_i`=0 and `ld_b2a_ni`=0 at an edge, `a_o` shows the sampled `b2_i` after that edge.
- R5: If the select is the same at two successive edges and the selected return register's enable is 1 at the second edge, `a_o` holds. Loading the unselected return register does not change `a_o`.
- R6: The select is sampled only at the rising edge. A change between edges leaves `a_o` untouched until the next edge. Switching the select with both return enables at 1 presents the other return register's retained contents.
- R7: `a_drv_o` becomes 1 after an edge where `oe_a_ni`=0 and becomes 0 after an edge where `oe_a_ni`=1. The data registers keep loading while the port is not driven.
- R8: `b_drv_o` becomes 1 after an edge where `oe_b_ni`=0 and becomes 0 after an edge where `oe_b_ni`=1. This one flag covers both 1B and 2B.
- R9: While `rst_ni`=0, `a_o`, `b1_o` and `b2_o` are zero and both drive flags are 0. The captured select resets to the 2B path (value 0).
- R10: Loads in both directions at the same edge are independent. Each register takes its own source value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | DATA_W | Value present on port A |
| a_o | output | DATA_W | Value driven towards port A |
| a_drv_o | output | 1 | Port A drive flag |
| b1_i | input | DATA_W | Value present on port 1B |
| b1_o | output | DATA_W | Value driven towards port 1B |
| b2_i | input | DATA_W | Value present on port 2B |
| b2_o | output | DATA_W | Value driven towards port 2B |
| b_drv_o | output | 1 | Shared drive flag for ports 1B and 2B |
| sel_b1_i | input | 1 | Return path select: 1 picks 1B, 0 picks 2B |
| ld_b1a_ni | input | 1 | Load enable of the 1B-to-A register, active low |
| ld_b2a_ni | input | 1 | Load enable of the 2B-to-A register, active low |
| ld_ab1_ni | input | 1 | Load enable of the A-to-1B register, active low |
| ld_ab2_ni | input | 1 | Load enable of the A-to-2B register, active low |
| oe_a_ni | input | 1 | Synchronous output enable for A, active low |
| oe_b_ni | input | 1 | Synchronous output enable for 1B and 2B, active low |

## Verification
The vector table drives distinct values on A, 1B and 2B, so a wrong source or a swapped path shows up as a wrong value.

- **Enable combinations:** the table steps through each single enable and through simultaneous forward and return loads. This separates the four registers from one another.
- **Select against return enables:** the selected return register is held while the other one loads, and the select is switched while both return enables are 1. These two cases distinguish a held return register from a single output register that merely follows the select.
- **Output enables:** the two enables are swept through all their combinations, and data is loaded while a port is not driven.
- **Directed cases:** a select change between edges, and a reset asserted in the middle of a cycle.

// File: rtl/exch_pkg.sv
package exch_pkg;
  localparam int unsigned DEF_W   = 12;
  localparam int unsigned NUM_FWD = 2;   // A->1B, A->2B
  localparam int unsigned NUM_RET = 2;   // 1B->A, 2B->A
  localparam int unsigned NUM_OE  = 2;   // A side, B side

  typedef enum logic {
    PATH_B2 = 1'b0,
    PATH_B1 = 1'b1
  } path_e;
endpackage

// File: rtl/exch_load_reg.sv
module exch_load_reg #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (!ld_ni) q_o <= d_i;
  end
endmodule

// File: rtl/exch_return_path.sv
module exch_return_path
  import exch_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      sel_b1_i,
  input  logic [NUM_RET-1:0]        ld_ni,    // [0]=1B, [1]=2B
  input  logic [NUM_RET-1:0][W-1:0] d_i,
  output logic [W-1:0]              q_o
);
  logic [NUM_RET-1:0][W-1:0] ret_q;
  path_e                     path_q;

  for (genvar i = 0; i < NUM_RET; i++) begin : g_ret
    exch_load_reg #(.W(W)) u_reg (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .ld_ni (ld_ni[i]),
      .d_i   (d_i[i]),
      .q_o   (ret_q[i])
    );
  end

  // select captured on the edge, never seen combinationally
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) path_q <= PATH_B2;
    else         path_q <= path_e'(sel_b1_i);
  end

  assign q_o = (path_q == PATH_B1) ? ret_q[0] : ret_q[1];
endmodule

// File: rtl/exch_oe_sync.sv
module exch_oe_sync #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] oe_ni,
  output logic [N-1:0] drv_o
);
  for (genvar i = 0; i < N; i++) begin : g_oe
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) drv_o[i] <= 1'b0;
      else         drv_o[i] <= ~oe_ni[i];
    end
  end
endmodule

// File: rtl/bus_exchanger.sv
module bus_exchanger
  import exch_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] a_i,
  output logic [DATA_W-1:0] a_o,
  output logic              a_drv_o,
  input  logic [DATA_W-1:0] b1_i,
  output logic [DATA_W-1:0] b1_o,
  input  logic [DATA_W-1:0] b2_i,
  output logic [DATA_W-1:0] b2_o,
  output logic              b_drv_o,
  input  logic              sel_b1_i,
  input  logic              ld_b1a_ni,
  input  logic              ld_b2a_ni,
  input  logic              ld_ab1_ni,
  input  logic              ld_ab2_ni,
  input  logic              oe_a_ni,
  input  logic              oe_b_ni
);
  logic [NUM_FWD-1:0]             fwd_ld_n;
  logic [NUM_FWD-1:0][DATA_W-1:0] fwd_q;
  logic [NUM_RET-1:0]             ret_ld_n;
  logic [NUM_RET-1:0][DATA_W-1:0] ret_d;
  logic [NUM_OE-1:0]              oe_n;
  logic [NUM_OE-1:0]              drv;

  assign fwd_ld_n = {ld_ab2_ni, ld_ab1_ni};
  assign ret_ld_n = {ld_b2a_ni, ld_b1a_ni};
  assign ret_d    = {b2_i, b1_i};
  assign oe_n     = {oe_b_ni, oe_a_ni};

  for (genvar i = 0; i < NUM_FWD; i++) begin : g_fwd
    exch_load_reg #(.W(DATA_W)) u_fwd (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .ld_ni (fwd_ld_n[i]),
      .d_i   (a_i),
      .q_o   (fwd_q[i])
    );
  end

  exch_return_path #(.W(DATA_W)) u_ret (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_b1_i(sel_b1_i),
    .ld_ni   (ret_ld_n),
    .d_i     (ret_d),
    .q_o     (a_o)
  );

  exch_oe_sync #(.N(NUM_OE)) u_oe (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .oe_ni (oe_n),
    .drv_o (drv)
  );

  assign b1_o    = fwd_q[0];
  assign b2_o    = fwd_q[1];
  assign a_drv_o = drv[0];
  assign b_drv_o = drv[1];
endmodule

// File: rtl/exch_chk.sv
module exch_chk #(
  parameter int unsigned DATA_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] a_o,
  input logic              a_drv_o,
  input logic [DATA_W-1:0] b1_i,
  input logic [DATA_W-1:0] b1_o,
  input logic [DATA_W-1:0] b2_i,
  input logic [DATA_W-1:0] b2_o,
  input logic              b_drv_o,
  input logic              sel_b1_i,
  input logic              ld_b1a_ni,
  input logic              ld_b2a_ni,
  input logic              ld_ab1_ni,
  input logic              ld_ab2_ni,
  input logic              oe_a_ni,
  input logic              oe_b_ni
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  // R1
  fwd_b1_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_ab1_ni |=> b1_o == $past(a_i));
  // R1
  fwd_b1_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_ab1_ni |=> $stable(b1_o));
  // R2
  fwd_b2_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_ab2_ni |=> b2_o == $past(a_i));
  // R2
  fwd_b2_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_ab2_ni |=> $stable(b2_o));
  // R3
  ret_b1_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_b1_i && !ld_b1a_ni) |=> a_o == $past(b1_i));
  // R4
  ret_b2_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_b1_i && !ld_b2a_ni) |=> a_o == $past(b2_i));
  // R5
  ret_b1_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && sel_b1_i && $past(sel_b1_i) && ld_b1a_ni) |=> $stable(a_o));
  // R5
  ret_b2_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !sel_b1_i && !$past(sel_b1_i) && ld_b2a_ni) |=> $stable(a_o));
  // R7
  oe_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> a_drv_o == !$past(oe_a_ni));
  // R8
  oe_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> b_drv_o == !$past(oe_b_ni));
  // R9
  reset_state_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (a_o == '0 && b1_o == '0 && b2_o == '0 && !a_drv_o && !b_drv_o));
endmodule

bind bus_exchanger exch_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .a_i      (a_i),
  .a_o      (a_o),
  .a_drv_o  (a_drv_o),
  .b1_i     (b1_i),
  .b1_o     (b1_o),
  .b2_i     (b2_i),
  .b2_o     (b2_o),
  .b_drv_o  (b_drv_o),
  .sel_b1_i (sel_b1_i),
  .ld_b1a_ni(ld_b1a_ni),
  .ld_b2a_ni(ld_b2a_ni),
  .ld_ab1_ni(ld_ab1_ni),
  .ld_ab2_ni(ld_ab2_ni),
  .oe_a_ni  (oe_a_ni),
  .oe_b_ni  (oe_b_ni)
);

// File: tb/bus_exchanger_test.sv
`timescale 1ns/1ps
module bus_exchanger_test;
  localparam int W = 12;

  typedef struct packed {
    logic [W-1:0] a, b1, b2;
    logic sel, ld_b1a_n, ld_b2a_n, ld_ab1_n, ld_ab2_n, oe_a_n, oe_b_n;
    logic [W-1:0] ea, eb1, eb2;
    logic ea_drv, eb_drv;
  } vec_t;

  localparam int NV = 10;
  // stimulus | expected after the edge
  localparam vec_t VEC [NV] = '{
    '{12'h123,12'h0AA,12'h055, 1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0, 12'h0AA,12'h123,12'h000, 1'b1,1'b1}, // R3 R1 R2 R10
    '{12'h456,12'h111,12'h222, 1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 12'h222,12'h123,12'h456, 1'b1,1'b1}, // R4 R2 R1
    '{12'h789,12'h333,12'h444, 1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0, 12'h222,12'h123,12'h456, 1'b1,1'b1}, // R5
    '{12'hABC,12'h555,12'h666, 1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0, 12'h333,12'h123,12'h456, 1'b1,1'b1}, // R6
    '{12'hABC,12'h888,12'h777, 1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0, 12'h333,12'h123,12'h456, 1'b1,1'b1}, // R5
    '{12'hDEF,12'h999,12'h777, 1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0, 12'h999,12'hDEF,12'hDEF, 1'b0,1'b1}, // R7 R10
    '{12'h000,12'h000,12'h000, 1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1, 12'h777,12'hDEF,12'hDEF, 1'b1,1'b0}, // R8 R6
    '{12'h000,12'h000,12'h000, 1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1, 12'h777,12'hDEF,12'hDEF, 1'b0,1'b0}, // R7 R8
    '{12'hA5A,12'h0F0,12'hF0F, 1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 12'h0F0,12'hA5A,12'hDEF, 1'b1,1'b1}, // R10
    '{12'h000,12'h000,12'h000, 1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0, 12'hF0F,12'hA5A,12'hDEF, 1'b1,1'b1}  // R6
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [W-1:0] a_i = '0, b1_i = '0, b2_i = '0;
  logic [W-1:0] a_o, b1_o, b2_o;
  logic a_drv_o, b_drv_o;
  logic sel_b1_i = 1'b0, ld_b1a_ni = 1'b1, ld_b2a_ni = 1'b1;
  logic ld_ab1_ni = 1'b1, ld_ab2_ni = 1'b1, oe_a_ni = 1'b1, oe_b_ni = 1'b1;
  int checks = 0, errors = 0;

  always #10 clk_i = ~clk_i;

  bus_exchanger #(.DATA_W(W)) uut (
    .clk_i, .rst_ni, .a_i, .a_o, .a_drv_o, .b1_i, .b1_o, .b2_i, .b2_o, .b_drv_o,
    .sel_b1_i, .ld_b1a_ni, .ld_b2a_ni, .ld_ab1_ni, .ld_ab2_ni, .oe_a_ni, .oe_b_ni
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic [W-1:0] ea, eb1, eb2,
                         input logic ead, ebd);
    chk({req, " a_o"}, a_o, ea);
    chk({req, " b1_o"}, b1_o, eb1);
    chk({req, " b2_o"}, b2_o, eb2);
    chk({req, " a_drv_o"}, {{(W-1){1'b0}}, a_drv_o}, {{(W-1){1'b0}}, ead});
    chk({req, " b_drv_o"}, {{(W-1){1'b0}}, b_drv_o}, {{(W-1){1'b0}}, ebd});
  endtask

  initial begin
    repeat (5000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    chk_all("R9 reset", '0, '0, '0, 1'b0, 1'b0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      a_i = VEC[i].a; b1_i = VEC[i].b1; b2_i = VEC[i].b2;
      sel_b1_i = VEC[i].sel;
      ld_b1a_ni = VEC[i].ld_b1a_n; ld_b2a_ni = VEC[i].ld_b2a_n;
      ld_ab1_ni = VEC[i].ld_ab1_n; ld_ab2_ni = VEC[i].ld_ab2_n;
      oe_a_ni = VEC[i].oe_a_n; oe_b_ni = VEC[i].oe_b_n;
      @(negedge clk_i);
      chk_all($sformatf("R1-vec%0d R3 R4 R5 R6 R7 R8", i),
              VEC[i].ea, VEC[i].eb1, VEC[i].eb2, VEC[i].ea_drv, VEC[i].eb_drv);
    end

    // R6: select change mid-cycle is invisible until the next edge
    ld_b1a_ni = 1'b1; ld_b2a_ni = 1'b1; ld_ab1_ni = 1'b1; ld_ab2_ni = 1'b1;
    sel_b1_i = 1'b1;
    #5;
    chk("R6 mid-cycle select", a_o, 12'hF0F);
    @(negedge clk_i);
    chk("R6 select after edge", a_o, 12'h0F0);

    // R9: asynchronous reset mid-cycle
    #5 rst_ni = 1'b0;
    #1;
    chk_all("R9 async reset", '0, '0, '0, 1'b0, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    sel_b1_i = 1'b1; oe_a_ni = 1'b0; oe_b_ni = 1'b0;
    @(negedge clk_i);
    chk_all("R9 cleared registers", '0, '0, '0, 1'b1, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule